// File: doc/BRIEF.md
# Dual-Core Atomic GPIO Output Bank

This block holds the output-level and output-drive-enable registers for a group of general-purpose pins. Two processor cores share it, and each core has its own simple register port with address, write data, write strobe and combinational read data. Each of the two registers has four write addresses. One loads the register outright. The other three set, clear or toggle only the bits that are 1 in the write data. Software can therefore change a few pins without a read-modify-write sequence.

When both cores write in the same cycle, the block resolves the writes in a fixed order. Core 0's operation is applied first, and core 1's operation is applied to that intermediate value. This holds even when the two cores use different alias kinds. Each access also carries a Non-secure attribute. A per-pin mask marks some pins as Secure-only. Non-secure accesses cannot change those pins and read them as zero. The pin inputs pass through a two-flop synchroniser and can be read back through the same ports.

Top module: `gpio_dual_out_bank`

## Requirements
- R1: A synchronous active-high reset clears both registers, so `pin_out` and `pin_oe` are all zeros in the cycle after reset.
- R2: A write to word 0 (byte address 0x00) loads the level register with the write data (1 = high, 0 = low), and `pin_out` shows it after the next clock edge.
- R3: Words 1, 2 and 3 (0x04, 0x08, 0x0C) update the level register as OUT | wdata, OUT & ~wdata and OUT ^ wdata respectively.
- R4: Words 4 to 7 (0x10 to 0x1C) use the same load/set/clear/toggle scheme on the drive-enable register, which drives `pin_oe` (1 = output, 0 = input).
- R5: Reading any of words 0-3 returns the level register, and reading any of words 4-7 returns the drive-enable register, never the pin levels.
- R6: Reading word 8 (0x20) returns `pin_in` after a two-flop synchroniser. A change on `pin_in` is visible after the second clock edge and not after the first.
- R7: When both cores write in the same cycle, the result equals core 0's operation followed by core 1's operation on that intermediate value. This holds for either register and any mix of aliases.
- R8: A write with the Non-secure attribute high leaves every pin whose `secure_only_mask` bit is 1 unchanged, for all four aliases.
- R9: A read with the Non-secure attribute high returns zero on every pin whose `secure_only_mask` bit is 1, for the level, drive-enable and input words.
- R10: A read with the Non-secure attribute low sees every pin, whatever the mask.
- R11: Writes to word 8, to words 9-15, or to addresses whose two low bits are not zero change nothing. Reads of words 9-15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core0_addr | input | ADDR_W | Core 0 byte address |
| core0_wdata | input | NPIN | Core 0 write data |
| core0_we | input | 1 | Core 0 write strobe |
| core0_nonsec | input | 1 | Core 0 access is Non-secure |
| core0_rdata | output | NPIN | Core 0 read data for the current address |
| core1_addr | input | ADDR_W | Core 1 byte address |
| core1_wdata | input | NPIN | Core 1 write data |
| core1_we | input | 1 | Core 1 write strobe |
| core1_nonsec | input | 1 | Core 1 access is Non-secure |
| core1_rdata | output | NPIN | Core 1 read data for the current address |
| secure_only_mask | input | NPIN | 1 marks a pin as Secure-only |
| pin_in | input | NPIN | Pin levels, asynchronous |
| pin_out | output | NPIN | Output level per pin |
| pin_oe | output | NPIN | Output drive enable per pin |

## Verification
A fault in the register state shows on `pin_out` or `pin_oe` after a single clock edge. It also shows on both read ports in the same cycle, so the bench compares the pins and the read data after every write cycle. A fault in the ordering or masking logic shows only for certain combinations: an alias pair, a register pair and a Non-secure pattern. For that reason the bench sweeps every combination of both cores' alias, target register and security attribute. A synchroniser with the wrong depth shows as input data that arrives one edge too early or too late.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } alias_op_e;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_LEVEL  = 2'd1,
        SEL_DRIVE  = 2'd2,
        SEL_SAMPLE = 2'd3
    } read_sel_e;

    typedef struct packed {
        logic      wr_level;
        logic      wr_drive;
        alias_op_e op;
    } wr_req_t;

    localparam int WORD_DRIVE_BASE = 4;
    localparam int WORD_SAMPLE     = 8;

    // One bit of one alias operation; allow = 0 keeps the current bit.
    function automatic logic alias_bit(logic cur, alias_op_e op, logic d, logic allow);
        logic nxt;
        case (op)
            OP_LOAD:   nxt = d;
            OP_SET:    nxt = cur | d;
            OP_CLEAR:  nxt = cur & ~d;
            default:   nxt = cur ^ d;
        endcase
        return allow ? nxt : cur;
    endfunction

endpackage

// File: rtl/gpo_port_decode.sv
module gpo_port_decode
    import gpo_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output wr_req_t           req,
    output read_sel_e         rsel
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;

    assign word    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        req.op       = alias_op_e'(word[1:0]);
        req.wr_level = we && aligned && (word < WORD_W'(WORD_DRIVE_BASE));
        req.wr_drive = we && aligned && (word >= WORD_W'(WORD_DRIVE_BASE))
                          && (word < WORD_W'(WORD_SAMPLE));
        if (!aligned)                             rsel = SEL_NONE;
        else if (word < WORD_W'(WORD_DRIVE_BASE)) rsel = SEL_LEVEL;
        else if (word < WORD_W'(WORD_SAMPLE))     rsel = SEL_DRIVE;
        else if (word == WORD_W'(WORD_SAMPLE))    rsel = SEL_SAMPLE;
        else                                      rsel = SEL_NONE;
    end
endmodule

// File: rtl/gpo_alias_reg.sv
module gpo_alias_reg
    import gpo_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic      [1:0]       wr_en,
    input  alias_op_e [1:0]       ops,
    input  logic      [1:0][W-1:0] data,
    input  logic      [1:0][W-1:0] allow,
    output logic      [W-1:0]     val_q
);
    logic [W-1:0] mid, val_d, gate0, gate1;

    assign gate0 = wr_en[0] ? allow[0] : '0;
    assign gate1 = wr_en[1] ? allow[1] : '0;

    // Core 0 first, core 1 on the intermediate result.
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign mid[b]   = alias_bit(val_q[b], ops[0], data[0][b], gate0[b]);
        assign val_d[b] = alias_bit(mid[b],   ops[1], data[1][b], gate1[b]);
    end

    always_ff @(posedge clk) begin
        if (rst) val_q <= '0;
        else     val_q <= val_d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (val_q == '0));
    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en == 2'b00) |=> $stable(val_q));
    // R3
    set_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en != 2'b00) && (!wr_en[0] || ops[0] == OP_SET) && (!wr_en[1] || ops[1] == OP_SET)
        |=> (($past(val_q) & ~val_q) == '0));
    // R3
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en != 2'b00) && (!wr_en[0] || ops[0] == OP_CLEAR) && (!wr_en[1] || ops[1] == OP_CLEAR)
        |=> ((~$past(val_q) & val_q) == '0));
    // R8
    locked_bits_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((val_q & ~($past(gate0) | $past(gate1)))
                  == ($past(val_q) & ~($past(gate0) | $past(gate1)))));
    // R7
    last_load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en[1] && ops[1] == OP_LOAD && (&allow[1]) |=> (val_q == $past(data[1])));
endmodule

// File: rtl/gpo_in_sync.sv
module gpo_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)        chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else            chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_dual_out_bank.sv
module gpio_dual_out_bank
    import gpo_pkg::*;
#(
    parameter int NPIN   = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] core0_addr,
    input  logic [NPIN-1:0]   core0_wdata,
    input  logic              core0_we,
    input  logic              core0_nonsec,
    output logic [NPIN-1:0]   core0_rdata,
    input  logic [ADDR_W-1:0] core1_addr,
    input  logic [NPIN-1:0]   core1_wdata,
    input  logic              core1_we,
    input  logic              core1_nonsec,
    output logic [NPIN-1:0]   core1_rdata,
    input  logic [NPIN-1:0]   secure_only_mask,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe
);
    localparam int NCORE = 2;

    logic      [NCORE-1:0][ADDR_W-1:0] addr_a;
    logic      [NCORE-1:0][NPIN-1:0]   wdata_a, view_a, rdata_a;
    logic      [NCORE-1:0]             we_a, nonsec_a, lvl_en, drv_en;
    wr_req_t   [NCORE-1:0]             req_a;
    read_sel_e [NCORE-1:0]             rsel_a;
    alias_op_e [NCORE-1:0]             op_a;
    logic      [NPIN-1:0]              level_q, drive_q, sample_q;

    assign addr_a   = {core1_addr, core0_addr};
    assign wdata_a  = {core1_wdata, core0_wdata};
    assign we_a     = {core1_we, core0_we};
    assign nonsec_a = {core1_nonsec, core0_nonsec};

    for (genvar p = 0; p < NCORE; p++) begin : g_port
        gpo_port_decode #(.ADDR_W(ADDR_W)) u_dec (
            .addr (addr_a[p]),
            .we   (we_a[p]),
            .req  (req_a[p]),
            .rsel (rsel_a[p])
        );

        assign view_a[p] = nonsec_a[p] ? ~secure_only_mask : '1;
        assign lvl_en[p] = req_a[p].wr_level;
        assign drv_en[p] = req_a[p].wr_drive;
        assign op_a[p]   = req_a[p].op;

        always_comb begin
            case (rsel_a[p])
                SEL_LEVEL:  rdata_a[p] = level_q  & view_a[p];
                SEL_DRIVE:  rdata_a[p] = drive_q  & view_a[p];
                SEL_SAMPLE: rdata_a[p] = sample_q & view_a[p];
                default:    rdata_a[p] = '0;
            endcase
        end

        // R9
        nonsec_hidden_chk: assert property (@(posedge clk) disable iff (rst)
            nonsec_a[p] |-> ((rdata_a[p] & secure_only_mask) == '0));
        // R5
        level_readback_chk: assert property (@(posedge clk) disable iff (rst)
            (rsel_a[p] == SEL_LEVEL) && !nonsec_a[p] |-> (rdata_a[p] == pin_out));
    end

    gpo_alias_reg #(.W(NPIN)) u_level (
        .clk   (clk),
        .rst   (rst),
        .wr_en (lvl_en),
        .ops   (op_a),
        .data  (wdata_a),
        .allow (view_a),
        .val_q (level_q)
    );

    gpo_alias_reg #(.W(NPIN)) u_drive (
        .clk   (clk),
        .rst   (rst),
        .wr_en (drv_en),
        .ops   (op_a),
        .data  (wdata_a),
        .allow (view_a),
        .val_q (drive_q)
    );

    gpo_in_sync #(.W(NPIN), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sample_q)
    );

    assign core0_rdata = rdata_a[0];
    assign core1_rdata = rdata_a[1];
    assign pin_out     = level_q;
    assign pin_oe      = drive_q;
endmodule

// File: tb/gpio_dual_out_bank_test.sv
module gpio_dual_out_bank_test;
    localparam int NPIN = 16;
    localparam int AW   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0]   a0 = '0, a1 = '0;
    logic [NPIN-1:0] d0 = '0, d1 = '0, r0, r1;
    logic            we0 = 1'b0, we1 = 1'b0, ns0 = 1'b0, ns1 = 1'b0;
    logic [NPIN-1:0] mask = '0, pins = '0, pout, poe;

    int checks = 0, fails = 0;
    logic done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;
    logic [NPIN-1:0] exp_lvl = '0, exp_drv = '0;

    always #2.5 clk = ~clk;

    gpio_dual_out_bank #(.NPIN(NPIN), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst),
        .core0_addr(a0), .core0_wdata(d0), .core0_we(we0), .core0_nonsec(ns0), .core0_rdata(r0),
        .core1_addr(a1), .core1_wdata(d1), .core1_we(we1), .core1_nonsec(ns1), .core1_rdata(r1),
        .secure_only_mask(mask), .pin_in(pins), .pin_out(pout), .pin_oe(poe)
    );

    task automatic chk(string tag, logic [NPIN-1:0] act, logic [NPIN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nxt(output logic [NPIN-1:0] v);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        v = seed[NPIN-1:0];
    endtask

    function automatic logic [NPIN-1:0] model(logic [NPIN-1:0] cur, int op,
                                              logic [NPIN-1:0] d, logic [NPIN-1:0] allow);
        logic [NPIN-1:0] n;
        case (op)
            0: n = d;
            1: n = cur | d;
            2: n = cur & ~d;
            default: n = cur ^ d;
        endcase
        return (cur & ~allow) | (n & allow);
    endfunction

    function automatic logic [AW-1:0] waddr(int w);
        return AW'(w * 4);
    endfunction

    task automatic idle();
        we0 = 1'b0; we1 = 1'b0; ns0 = 1'b0; ns1 = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [NPIN-1:0] v, w, al0, al1, pa, pb;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 pin_out", pout, '0);
        chk("R1 pin_oe", poe, '0);
        a0 = waddr(0); #1 chk("R1 level read", r0, '0);

        // R2: plain load of the level register
        @(negedge clk);
        a0 = waddr(0); d0 = 16'hA5C3; we0 = 1'b1;
        cyc(); idle();
        exp_lvl = 16'hA5C3;
        chk("R2 load", pout, exp_lvl);

        // Sweep R3/R4/R7/R8 and read-back R5/R9
        pins = 16'h0F0F;
        for (int r0i = 0; r0i < 2; r0i++)
        for (int r1i = 0; r1i < 2; r1i++) begin
            nxt(v); mask = v;
            for (int o0 = 0; o0 < 4; o0++)
            for (int o1 = 0; o1 < 4; o1++)
            for (int ns = 0; ns < 4; ns++) begin
                nxt(v); nxt(w);
                a0 = waddr(r0i * 4 + o0); d0 = v; we0 = 1'b1; ns0 = ns[0];
                a1 = waddr(r1i * 4 + o1); d1 = w; we1 = 1'b1; ns1 = ns[1];
                al0 = ns[0] ? ~mask : '1;
                al1 = ns[1] ? ~mask : '1;
                if (r0i == 0) exp_lvl = model(exp_lvl, o0, v, al0);
                else          exp_drv = model(exp_drv, o0, v, al0);
                if (r1i == 0) exp_lvl = model(exp_lvl, o1, w, al1);
                else          exp_drv = model(exp_drv, o1, w, al1);
                cyc(); idle();
                if (ns != 0) begin
                    chk("R8 pin_out", pout, exp_lvl);
                    chk("R8 pin_oe", poe, exp_drv);
                end else if (r0i == r1i) begin
                    chk("R7 pin_out", pout, exp_lvl);
                    chk("R7 pin_oe", poe, exp_drv);
                end else begin
                    chk("R3 pin_out", pout, exp_lvl);
                    chk("R4 pin_oe", poe, exp_drv);
                end
                a0 = waddr(o0); a1 = waddr(4 + o1); ns1 = 1'b1;
                #1;
                chk("R5 level read", r0, exp_lvl);
                chk("R9 drive read nonsec", r1, exp_drv & ~mask);
                a1 = waddr(o1); #1;
                chk("R9 level read nonsec", r1, exp_lvl & ~mask);
                ns1 = 1'b0;
                @(negedge clk);
            end
        end

        // R6: two-flop input synchroniser
        pa = 16'h3C5A; pb = 16'hC3A5;
        pins = pa; cyc(); cyc(); cyc();
        a0 = waddr(8); ns0 = 1'b0; #1 chk("R6 settled", r0, pa);
        @(negedge clk); pins = pb;
        cyc(); chk("R6 after one edge", r0, pa);
        cyc(); chk("R6 after two edges", r0, pb);
        // R9 / R10 on the input word
        mask = 16'h00FF;
        a1 = waddr(8); ns1 = 1'b1; #1;
        chk("R9 input nonsec", r1, pb & ~mask);
        chk("R10 input secure", r0, pb);
        ns1 = 1'b0; #1 chk("R10 input secure core1", r1, pb);

        // R11: unmapped, input and misaligned writes
        @(negedge clk);
        for (int wd = 8; wd < 16; wd++) begin
            a0 = waddr(wd); d0 = '1; we0 = 1'b1;
            a1 = waddr(0) | AW'(wd % 3 + 1); d1 = '1; we1 = 1'b1;
            cyc(); idle();
            chk("R11 pin_out", pout, exp_lvl);
            chk("R11 pin_oe", poe, exp_drv);
            if (wd > 8) begin
                a0 = waddr(wd); #1 chk("R11 unmapped read", r0, '0);
            end
        end

        // R1: reset mid-run
        @(negedge clk);
        a0 = waddr(0); d0 = '1; we0 = 1'b1; a1 = waddr(4); d1 = '1; we1 = 1'b1;
        cyc(); idle();
        rst = 1'b1; cyc(); rst = 1'b0;
        chk("R1 pin_out after reset", pout, '0);
        chk("R1 pin_oe after reset", poe, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule